// File: doc/BRIEF.md
# Dual Masked Alarm Comparator

This block keeps two alarm register sets and compares each one against the running calendar time. Each set has six bytes: seconds, minutes, hours, date, month and day of week. The top bit of every byte is an enable for that field, so software can build alarms such as "every minute at second 30", "daily at 07:15" or "each Friday at noon". The comparison runs once per clock update, on a one-cycle strobe from the time counter. A match sets a sticky per-alarm flag.

A status read clears the flags in two steps. A start strobe records which flags are set. An end strobe clears only those recorded flags, so an alarm that fires while the read is in progress is not lost. Each flag can be routed to one active-low interrupt line. That line either follows the routed flags (level mode) or gives a fixed-length low pulse on each routed match (repeat mode).

Top module: `alm_cmp_top`

## Requirements
- R1: After synchronous reset both flags are 0, `irq_n` is 1, every stored alarm byte reads 0 and the pulse counter is idle.
- R2: `reg_idx` selects the field: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week. `reg_sel` selects alarm 0 or 1. A write takes effect at the clock edge. `reg_rdata` shows the selected byte combinationally. Codes 6 and 7 ignore writes and read as 0.
- R3: Bit 7 of each alarm byte enables that field. Only enabled fields are compared, and only over these value bits: seconds and minutes 6:0, hours 5:0, date 5:0, month 4:0, day of week 2:0. Bits 7 and 6 of the clock hour input (format select and AM/PM) never affect a match.
- R4: An alarm whose six enable bits are all 0 never sets its flag.
- R5: Matching happens only in a cycle where `tick` is 1. The flag is set at the next clock edge. A matching time without `tick` sets nothing.
- R6: `al_flag[0]` belongs to alarm 0 and `al_flag[1]` belongs to alarm 1. A flag stays set until it is cleared by a status read.
- R7: `sr_rd_start` records the current flags. `sr_rd_end` clears exactly the recorded flags at its clock edge and then forgets the record. A flag set after the start, or set by a match in the same cycle as the end, remains 1.
- R8: With `repeat_mode` = 0, `irq_n` is 0 exactly while some flag is set whose bit in `irq_en` is 1.
- R9: With `repeat_mode` = 1, a tick-cycle match of an alarm enabled in `irq_en` drives `irq_n` low for PULSE_CYC cycles, starting the cycle after the tick. A new such match reloads the count.
- R10: An alarm whose `irq_en` bit is 0 still sets its flag but never pulls `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at each time update |
| cur_sec | input | 8 | Live seconds (BCD) |
| cur_min | input | 8 | Live minutes (BCD) |
| cur_hour | input | 8 | Live hours; bits 7:6 ignored |
| cur_date | input | 8 | Live date (BCD) |
| cur_mon | input | 8 | Live month (BCD) |
| cur_dow | input | 8 | Live day of week |
| reg_we | input | 1 | Alarm byte write strobe |
| reg_sel | input | 1 | Alarm set select |
| reg_idx | input | 3 | Field code |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Selected alarm byte |
| sr_rd_start | input | 1 | Status read begins |
| sr_rd_end | input | 1 | Status read completes |
| irq_en | input | 2 | Per-alarm interrupt routing |
| repeat_mode | input | 1 | 0 level interrupt, 1 pulse per match |
| al_flag | output | 2 | Sticky alarm flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a status read that overlaps a new match. One flag must be set when the read starts, and the other alarm must then match on a tick between the start and the end strobes. The bench builds this on purpose: it starts a read with alarm 0 already flagged, writes a day-of-week alarm into set 1, ticks it and then ends the read. Long random runs then draw clock fields from only two values per field, so matches, masked fields and overlapping reads happen often. A behavioural model checks every cycle.

// File: rtl/alm_pkg.sv
package alm_pkg;
    // Field codes: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 day of week
    localparam int NF     = 6;
    localparam int IDXW   = 3;
    localparam int EN_BIT = 7;

    typedef logic [NF-1:0][7:0] aset_t;

    // Value bits that take part in a comparison, per field code
    function automatic logic [7:0] fld_mask(int f);
        case (f)
            0, 1:    fld_mask = 8'h7F;
            2, 3:    fld_mask = 8'h3F;
            4:       fld_mask = 8'h1F;
            default: fld_mask = 8'h07;
        endcase
    endfunction
endpackage

// File: rtl/alm_store.sv
module alm_store
    import alm_pkg::*;
#(
    parameter  int NA = 2,
    localparam int SW = (NA > 1) ? $clog2(NA) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SW-1:0]     sel,
    input  logic [IDXW-1:0]   idx,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output aset_t [NA-1:0]    sets
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sets <= '0;
        end else if (we) begin
            for (int a = 0; a < NA; a++)
                for (int f = 0; f < NF; f++)
                    if (sel == SW'(a) && idx == IDXW'(f))
                        sets[a][f] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int a = 0; a < NA; a++)
            for (int f = 0; f < NF; f++)
                if (sel == SW'(a) && idx == IDXW'(f))
                    rdata = sets[a][f];
    end
endmodule

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
(
    input  logic  tick,
    input  aset_t aset,
    input  aset_t now,
    output logic  hit
);
    logic [NF-1:0] en;
    logic [NF-1:0] eq;

    for (genvar f = 0; f < NF; f++) begin : g_fld
        assign en[f] = aset[f][EN_BIT];
        assign eq[f] = ((aset[f] ^ now[f]) & fld_mask(f)) == 8'h00;
    end

    assign hit = tick && (|en) && (&(eq | ~en));
endmodule

// File: rtl/alm_flags.sv
module alm_flags #(
    parameter  int NA        = 2,
    parameter  int PULSE_CYC = 4,
    localparam int CW        = $clog2(PULSE_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NA-1:0] hit,
    input  logic          rd_start,
    input  logic          rd_end,
    input  logic [NA-1:0] irq_en,
    input  logic          repeat_mode,
    output logic [NA-1:0] flag,
    output logic          irq_n
);
    logic [NA-1:0] snap;
    logic [NA-1:0] clr;
    logic [CW-1:0] cnt;

    assign clr = rd_end ? snap : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= '0;
            snap <= '0;
            cnt  <= '0;
        end else begin
            flag <= (flag & ~clr) | hit;
            if (rd_start)
                snap <= flag;
            else if (rd_end)
                snap <= '0;
            if (|(hit & irq_en))
                cnt <= CW'(PULSE_CYC);
            else if (cnt != '0)
                cnt <= cnt - CW'(1);
        end
    end

    assign irq_n = repeat_mode ? (cnt == '0) : ~|(flag & irq_en);

    for (genvar i = 0; i < NA; i++) begin : g_chk
        // R5
        set_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(flag[i]) |-> $past(hit[i]));
        // R7
        clear_snap_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_end && snap[i] && !hit[i]) |=> !flag[i]);
        // R7
        keep_late_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_end && !snap[i] && flag[i]) |=> flag[i]);
    end

    // R9
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        (repeat_mode && |(hit & irq_en)) |=> (!irq_n || !repeat_mode));
endmodule

// File: rtl/alm_cmp_top.sv
module alm_cmp_top
    import alm_pkg::*;
#(
    parameter  int NUM_AL    = 2,
    parameter  int PULSE_CYC = 4,
    localparam int SW        = (NUM_AL > 1) ? $clog2(NUM_AL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hour,
    input  logic [7:0]        cur_date,
    input  logic [7:0]        cur_mon,
    input  logic [7:0]        cur_dow,
    input  logic              reg_we,
    input  logic [SW-1:0]     reg_sel,
    input  logic [IDXW-1:0]   reg_idx,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              sr_rd_start,
    input  logic              sr_rd_end,
    input  logic [NUM_AL-1:0] irq_en,
    input  logic              repeat_mode,
    output logic [NUM_AL-1:0] al_flag,
    output logic              irq_n
);
    aset_t              now;
    aset_t [NUM_AL-1:0] sets;
    logic  [NUM_AL-1:0] hit;

    assign now[0] = cur_sec;
    assign now[1] = cur_min;
    assign now[2] = cur_hour;
    assign now[3] = cur_date;
    assign now[4] = cur_mon;
    assign now[5] = cur_dow;

    alm_store #(.NA(NUM_AL)) u_store (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .idx(reg_idx),
        .wdata(reg_wdata), .rdata(reg_rdata), .sets(sets)
    );

    for (genvar a = 0; a < NUM_AL; a++) begin : g_alm
        alm_match u_match (.tick(tick), .aset(sets[a]), .now(now), .hit(hit[a]));
    end

    alm_flags #(.NA(NUM_AL), .PULSE_CYC(PULSE_CYC)) u_flags (
        .clk(clk), .rst(rst), .hit(hit), .rd_start(sr_rd_start), .rd_end(sr_rd_end),
        .irq_en(irq_en), .repeat_mode(repeat_mode), .flag(al_flag), .irq_n(irq_n)
    );

    // R2
    rd_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && int'(reg_idx) < NF) |=>
        (!($stable(reg_sel) && $stable(reg_idx)) || reg_rdata == $past(reg_wdata)));
endmodule

// File: tb/alm_cmp_top_test.sv
module alm_cmp_top_test;
    localparam int PC = 4;

    logic clk = 0;
    logic rst = 1;
    always #10 clk = ~clk;

    logic       tick = 0;
    logic [7:0] cs = 0, cm = 0, ch = 0, cd = 0, cmo = 0, cw = 0;
    logic       we = 0;
    logic [0:0] sel = 0;
    logic [2:0] idx = 0;
    logic [7:0] wd = 0;
    logic       st = 0, en = 0, rep = 0;
    logic [1:0] ie = 0;
    wire  [7:0] rd;
    wire  [1:0] fl;
    wire        irqn;

    int vectors = 0;
    int errors  = 0;

    alm_cmp_top #(.NUM_AL(2), .PULSE_CYC(PC)) uut (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_sec(cs), .cur_min(cm), .cur_hour(ch), .cur_date(cd), .cur_mon(cmo), .cur_dow(cw),
        .reg_we(we), .reg_sel(sel), .reg_idx(idx), .reg_wdata(wd), .reg_rdata(rd),
        .sr_rd_start(st), .sr_rd_end(en), .irq_en(ie), .repeat_mode(rep),
        .al_flag(fl), .irq_n(irqn)
    );

    // Behavioural reference
    int mreg [2][8];
    int mflag = 0, msnap = 0, mcnt = 0;

    function automatic int fmask(int f);
        case (f)
            0, 1:    return 'h7F;
            2, 3:    return 'h3F;
            4:       return 'h1F;
            default: return 'h07;
        endcase
    endfunction

    function automatic int clockv(int f);
        case (f)
            0: return int'(cs);
            1: return int'(cm);
            2: return int'(ch);
            3: return int'(cd);
            4: return int'(cmo);
            default: return int'(cw);
        endcase
    endfunction

    function automatic bit mhit(int a);
        bit any = 0;
        bit ok  = 1;
        for (int f = 0; f < 6; f++) begin
            if (mreg[a][f][7]) begin
                any = 1;
                if ((mreg[a][f] & fmask(f)) != (clockv(f) & fmask(f))) ok = 0;
            end
        end
        return tick && any && ok;
    endfunction

    always @(posedge clk) begin : model
        int h, clr;
        if (rst) begin
            for (int a = 0; a < 2; a++)
                for (int f = 0; f < 8; f++) mreg[a][f] = 0;
            mflag = 0; msnap = 0; mcnt = 0;
        end else begin
            h = 0;
            for (int a = 0; a < 2; a++) if (mhit(a)) h |= (1 << a);
            clr = en ? msnap : 0;
            if (we && idx < 6) mreg[sel][idx] = int'(wd);
            if ((h & int'(ie)) != 0) mcnt = PC;
            else if (mcnt > 0) mcnt--;
            if (st) msnap = mflag;
            else if (en) msnap = 0;
            mflag = (mflag & ~clr) | h;
        end
    end

    task automatic fail(string req, int act, int exp);
        errors++;
        $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    endtask

    task automatic expect_eq(string req, int act, int exp);
        vectors++;
        if (act != exp) fail(req, act, exp);
    endtask

    task automatic cmp();
        int exp_rd, exp_irq;
        exp_rd  = (idx < 6) ? mreg[sel][idx] : 0;
        exp_irq = rep ? (mcnt == 0) : ((mflag & int'(ie)) == 0);
        vectors++;
        if (int'(fl) != mflag) fail("R6 flags", int'(fl), mflag);
        if (int'(rd) != exp_rd) fail("R2 rdata", int'(rd), exp_rd);
        if (int'(irqn) != exp_irq) fail(rep ? "R9 irq_n" : "R8 irq_n", int'(irqn), exp_irq);
    endtask

    task automatic go(int n);
        repeat (n) begin
            @(negedge clk);
            cmp();
            tick = 0; we = 0; st = 0; en = 0;
        end
    endtask

    task automatic wr(int a, int i, int d);
        we = 1; sel = 1'(a); idx = 3'(i); wd = 8'(d);
        go(1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        fail("R1 watchdog", 0, 1);
        finish_run();
    end

    initial begin
        go(3);
        rst = 0;
        sel = 1; idx = 2;
        go(1);
        expect_eq("R1 flags", int'(fl), 0);
        expect_eq("R1 irq_n", int'(irqn), 1);
        expect_eq("R1 rdata", int'(rd), 0);

        wr(0, 0, 'h85);
        wr(0, 1, 'h92);
        wr(0, 2, 'h88);
        wr(0, 6, 'hFF);
        sel = 0; idx = 0; go(1);
        expect_eq("R2 read sec", int'(rd), 'h85);
        idx = 6; go(1);
        expect_eq("R2 code 6", int'(rd), 0);
        idx = 2; go(1);
        expect_eq("R2 read hour", int'(rd), 'h88);

        cs = 8'h05; cm = 8'h12; ch = 8'hC8; cd = 8'h01; cmo = 8'h01; cw = 8'h03;
        ie = 2'b01; rep = 0;
        go(3);
        expect_eq("R5 no tick", int'(fl), 0);
        tick = 1; go(1);
        expect_eq("R3 masked match", int'(fl), 1);
        expect_eq("R8 level irq", int'(irqn), 0);
        tick = 1; go(1);
        expect_eq("R4 idle alarm", int'(fl[1]), 0);

        st = 1; go(1);
        wr(1, 5, 'h83);
        tick = 1; go(1);
        expect_eq("R7 late set", int'(fl), 3);
        en = 1; go(1);
        expect_eq("R7 partial clear", int'(fl), 2);
        go(1);
        expect_eq("R10 unrouted", int'(irqn), 1);

        st = 1; go(1);
        en = 1; go(1);
        expect_eq("R7 full clear", int'(fl), 0);
        ie = 2'b11; rep = 1;
        tick = 1; go(1);
        expect_eq("R9 pulse first", int'(irqn), 0);
        for (int k = 1; k < PC; k++) begin
            go(1);
            expect_eq("R9 pulse hold", int'(irqn), 0);
        end
        go(1);
        expect_eq("R9 pulse end", int'(irqn), 1);
        rep = 0; go(1);
        expect_eq("R8 level again", int'(irqn), 0);

        for (int n = 0; n < 5000; n++) begin
            tick = ($urandom % 4) == 0;
            st   = ($urandom % 10) == 0;
            en   = ($urandom % 8) == 0;
            sel  = 1'($urandom % 2);
            idx  = 3'($urandom % 8);
            if (($urandom % 5) == 0) begin
                we = 1;
                wd = {1'(($urandom % 3) == 0), 6'b0, 1'($urandom % 2)};
            end
            cs  = 8'($urandom % 2);
            cm  = 8'($urandom % 2);
            ch  = 8'($urandom % 2) | (8'($urandom % 2) << 7);
            cd  = 8'($urandom % 2);
            cmo = 8'($urandom % 2);
            cw  = 8'($urandom % 2);
            if (($urandom % 50) == 0) ie = 2'($urandom % 4);
            if (($urandom % 60) == 0) rep = ~rep;
            go(1);
        end
        finish_run();
    end
endmodule